// File: doc/BRIEF.md
# Phase-Continuous Caller-ID FSK Modulator

This block turns caller-ID bytes into a stream of signed 16-bit binary-FSK samples, one sample per pulse of a 24 kHz strobe. Software writes a byte into a one-deep holding register. The byte moves into a shift frame as soon as the modulator is free. At that moment a byte-request interrupt goes pending, so the next byte can be written while the current one is on the line. Each byte goes out least-significant bit first. It is either wrapped in a start bit (space) and a stop bit (mark), or sent as eight bare bits.

Every bit lasts a programmable number of strobes. A mark bit uses one frequency word and amplitude word, and a space bit uses another pair. One phase accumulator runs across every bit change and is never reloaded, so the tone switches frequency without a phase jump. The top six phase bits address a quarter-wave sine table. The result is scaled by the current bit's amplitude and clamped to 16 bits. When no byte is waiting, the line rests on a steady mark tone.

Register map (write-only, `cfg_addr_i`): 0 data byte in bits [7:0]; 1 control, bit 0 bare-byte mode, bit 1 interrupt enable, bit 2 transmit enable; 2 bit period; 3 mark frequency; 4 space frequency; 5 mark amplitude; 6 space amplitude; 7 bit 0 written as 1 clears the pending request.

Top module: `cid_fsk_mod`

## Requirements
- R1: After reset, `irq_o`=0, `sample_vld_o`=0, `sample_o`=0 and `line_bit_o`=1. Framing, interrupt enable and transmit enable all reset to 0.
- R2: With bare-byte mode 0, a byte goes out as 10 bits: a space start bit (0), then data bits 0 to 7 in that order, then a mark stop bit (1).
- R3: With bare-byte mode 1, a byte goes out as its 8 data bits, bit 0 first, with no start or stop bit.
- R4: Each bit occupies exactly P strobes, where P is the bit-period register. A period of 0 behaves as 1.
- R5: A byte written while another is being sent is held. Its first bit follows the previous byte's last bit on the very next strobe, with no idle gap. The request goes pending each time a byte enters the shifter.
- R6: The request stays pending until bit 0 of register 7 is written as 1. `irq_o` is the pending flag gated by the interrupt enable.
- R7: With no byte waiting, `line_bit_o` is 1 and the mark tone is produced.
- R8: Every strobe yields one `sample_vld_o` pulse one cycle later. The sample is sin(2π·φ/65536) × A/32768, where φ is the accumulator before the strobe and A is the amplitude of the bit on `line_bit_o` at that strobe. The sine is taken from a 64-step table whose value at step k is 32767·sin((2k+1)π/64). After each strobe the accumulator grows by the current bit's frequency word, modulo 2^16, and is never reset between bits.
- R9: Bits [2:0] of the frequency and amplitude words are ignored and treated as zero.
- R10: Scaled results beyond the signed 16-bit range clamp to 32767 or -32768.
- R11: With transmit enable 0, strobes give zero samples, the phase does not advance and no byte is loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | 24 kHz sample strobe, one cycle wide |
| cfg_we_i | input | 1 | Register write enable |
| cfg_addr_i | input | 3 | Register address |
| cfg_wdata_i | input | 16 | Register write data |
| irq_o | output | 1 | Byte-request interrupt |
| line_bit_o | output | 1 | Bit currently on the line (1 = mark) |
| sample_vld_o | output | 1 | Sample valid pulse |
| sample_o | output | 16 | Signed FSK sample |

## Verification
A register write takes effect at the next edge. A byte written while the modulator is idle enters the shifter one edge after that, and `irq_o` rises in the same cycle. The bench therefore waits two cycles after a data write before it checks the interrupt or sends strobes. `line_bit_o` is read in the cycle the strobe is driven, because it names the bit that strobe uses. The matching sample is compared one cycle later, at the falling edge after `sample_vld_o` rises. The bench advances its own phase model only after that comparison. Sine values are compared against a real-valued reference within a small tolerance.

// File: rtl/cid_fsk_pkg.sv
package cid_fsk_pkg;
    localparam int BYTE_W    = 8;
    localparam int FRAME_W   = 10;
    localparam int LEN_W     = $clog2(FRAME_W + 1);
    localparam int WORD_W    = 16;
    localparam int DROP_W    = 3;
    localparam int KEEP_W    = WORD_W - DROP_W;
    localparam int PHASE_W   = 16;
    localparam int LUT_ABITS = 4;
    localparam int SAMPLE_W  = 16;

    typedef enum logic [2:0] {
        A_DATA   = 3'd0,
        A_CTRL   = 3'd1,
        A_PERIOD = 3'd2,
        A_FMARK  = 3'd3,
        A_FSPACE = 3'd4,
        A_AMARK  = 3'd5,
        A_ASPACE = 3'd6,
        A_CLEAR  = 3'd7
    } reg_addr_e;

    typedef struct packed {
        logic [BYTE_W-1:0]          hold;
        logic                       hold_full;
        logic                       bare;
        logic                       irq_en;
        logic                       tx_en;
        logic [WORD_W-1:0]          period;
        logic [KEEP_W-1:0]          f_mark;
        logic [KEEP_W-1:0]          f_space;
        logic [KEEP_W-1:0]          a_mark;
        logic [KEEP_W-1:0]          a_space;
        logic [FRAME_W-1:0]         frame;
        logic [LEN_W-1:0]           remain;
        logic                       active;
        logic [WORD_W-1:0]          timer;
        logic [PHASE_W-1:0]         phase;
        logic                       pend;
        logic signed [SAMPLE_W-1:0] sample;
        logic                       vld;
    } fsk_state_t;
endpackage

// File: rtl/cid_fsk_sine.sv
module cid_fsk_sine
    import cid_fsk_pkg::*;
(
    input  logic [LUT_ABITS+1:0]        ph_i,
    output logic signed [SAMPLE_W-1:0]  wave_o
);
    logic [LUT_ABITS-1:0] idx;
    logic [SAMPLE_W-1:0]  mag;

    always_comb begin
        idx = ph_i[LUT_ABITS] ? ~ph_i[LUT_ABITS-1:0] : ph_i[LUT_ABITS-1:0];
        case (idx)
            4'd0:  mag = 16'd1608;
            4'd1:  mag = 16'd4808;
            4'd2:  mag = 16'd7962;
            4'd3:  mag = 16'd11039;
            4'd4:  mag = 16'd14010;
            4'd5:  mag = 16'd16846;
            4'd6:  mag = 16'd19519;
            4'd7:  mag = 16'd22005;
            4'd8:  mag = 16'd24279;
            4'd9:  mag = 16'd26319;
            4'd10: mag = 16'd28105;
            4'd11: mag = 16'd29621;
            4'd12: mag = 16'd30852;
            4'd13: mag = 16'd31785;
            4'd14: mag = 16'd32412;
            default: mag = 16'd32728;
        endcase
        wave_o = ph_i[LUT_ABITS+1] ? -$signed(mag) : $signed(mag);
    end
endmodule

// File: rtl/cid_fsk_scale.sv
module cid_fsk_scale
    import cid_fsk_pkg::*;
(
    input  logic signed [SAMPLE_W-1:0] wave_i,
    input  logic [WORD_W-1:0]          amp_i,
    output logic signed [SAMPLE_W-1:0] out_o
);
    localparam int PROD_W = SAMPLE_W + WORD_W + 1;
    localparam int SHIFT  = WORD_W - 1;
    localparam logic signed [PROD_W-1:0] MAX_V = PROD_W'(2**(SAMPLE_W-1) - 1);
    localparam logic signed [PROD_W-1:0] MIN_V = -PROD_W'(2**(SAMPLE_W-1));

    logic signed [PROD_W-1:0] w_ext, a_ext, prod, shifted;

    always_comb begin
        w_ext   = PROD_W'(wave_i);
        a_ext   = $signed({{(PROD_W-WORD_W){1'b0}}, amp_i});
        prod    = w_ext * a_ext;
        shifted = prod >>> SHIFT;
        if (shifted > MAX_V)      out_o = MAX_V[SAMPLE_W-1:0];
        else if (shifted < MIN_V) out_o = MIN_V[SAMPLE_W-1:0];
        else                      out_o = shifted[SAMPLE_W-1:0];
    end
endmodule

// File: rtl/cid_fsk_mod.sv
module cid_fsk_mod
    import cid_fsk_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       tick_i,
    input  logic                       cfg_we_i,
    input  logic [2:0]                 cfg_addr_i,
    input  logic [WORD_W-1:0]          cfg_wdata_i,
    output logic                       irq_o,
    output logic                       line_bit_o,
    output logic                       sample_vld_o,
    output logic signed [SAMPLE_W-1:0] sample_o
);
    localparam logic [LEN_W-1:0] LEN_FRAMED = LEN_W'(FRAME_W);
    localparam logic [LEN_W-1:0] LEN_BARE   = LEN_W'(BYTE_W);

    fsk_state_t q, d;

    logic                       cur_bit;
    logic [WORD_W-1:0]          freq_w, amp_w, last_cnt;
    logic signed [SAMPLE_W-1:0] wave, scaled;
    logic                       load_now;

    cid_fsk_sine u_sine (
        .ph_i   (q.phase[PHASE_W-1 -: LUT_ABITS+2]),
        .wave_o (wave)
    );

    cid_fsk_scale u_scale (
        .wave_i (wave),
        .amp_i  (amp_w),
        .out_o  (scaled)
    );

    always_comb begin
        cur_bit  = q.active ? q.frame[0] : 1'b1;
        freq_w   = cur_bit ? {q.f_mark, {DROP_W{1'b0}}} : {q.f_space, {DROP_W{1'b0}}};
        amp_w    = cur_bit ? {q.a_mark, {DROP_W{1'b0}}} : {q.a_space, {DROP_W{1'b0}}};
        last_cnt = (q.period == '0) ? '0 : q.period - 1'b1;
    end

    always_comb begin
        d        = q;
        d.vld    = 1'b0;
        load_now = 1'b0;

        if (tick_i) begin
            d.vld = 1'b1;
            if (q.tx_en) begin
                d.sample = scaled;
                d.phase  = q.phase + PHASE_W'(freq_w);
                if (q.active) begin
                    if (q.timer == last_cnt) begin
                        d.timer = '0;
                        if (q.remain == LEN_W'(1)) begin
                            if (q.hold_full) load_now = 1'b1;
                            else             d.active = 1'b0;
                        end else begin
                            d.frame  = {1'b1, q.frame[FRAME_W-1:1]};
                            d.remain = q.remain - 1'b1;
                        end
                    end else begin
                        d.timer = q.timer + 1'b1;
                    end
                end
            end else begin
                d.sample = '0;
            end
        end

        if (!q.active && q.hold_full && q.tx_en) load_now = 1'b1;

        if (load_now) begin
            d.frame     = q.bare ? {2'b11, q.hold} : {1'b1, q.hold, 1'b0};
            d.remain    = q.bare ? LEN_BARE : LEN_FRAMED;
            d.active    = 1'b1;
            d.timer     = '0;
            d.hold_full = 1'b0;
            d.pend      = 1'b1;
        end

        if (cfg_we_i) begin
            case (reg_addr_e'(cfg_addr_i))
                A_DATA: begin
                    d.hold      = cfg_wdata_i[BYTE_W-1:0];
                    d.hold_full = 1'b1;
                end
                A_CTRL: begin
                    d.bare   = cfg_wdata_i[0];
                    d.irq_en = cfg_wdata_i[1];
                    d.tx_en  = cfg_wdata_i[2];
                end
                A_PERIOD: d.period  = cfg_wdata_i;
                A_FMARK:  d.f_mark  = cfg_wdata_i[WORD_W-1:DROP_W];
                A_FSPACE: d.f_space = cfg_wdata_i[WORD_W-1:DROP_W];
                A_AMARK:  d.a_mark  = cfg_wdata_i[WORD_W-1:DROP_W];
                A_ASPACE: d.a_space = cfg_wdata_i[WORD_W-1:DROP_W];
                default: begin
                    if (cfg_wdata_i[0] && !load_now) d.pend = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign irq_o        = q.pend & q.irq_en;
    assign line_bit_o   = cur_bit;
    assign sample_vld_o = q.vld;
    assign sample_o     = q.sample;
endmodule

// File: rtl/cid_fsk_chk.sv
module cid_fsk_chk
    import cid_fsk_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input logic                 tick_i,
    input logic                 cfg_we_i,
    input logic [2:0]           cfg_addr_i,
    input logic [WORD_W-1:0]    cfg_wdata_i,
    input logic                 irq_o,
    input logic                 line_bit_o,
    input logic                 sample_vld_o,
    input logic [SAMPLE_W-1:0]  sample_o,
    input logic                 pend_q,
    input logic                 irq_en_q,
    input logic                 tx_en_q,
    input logic                 active_q,
    input logic                 hold_full_q,
    input logic [LEN_W-1:0]     remain_q,
    input logic [PHASE_W-1:0]   phase_q
);
    // R6: a pending request survives until a clearing write
    assert_pend_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q && !(cfg_we_i && cfg_addr_i == 3'd7 && cfg_wdata_i[0])) |=> pend_q);

    // R6: the interrupt pin follows the enable
    assert_irq_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> irq_en_q);

    // R3: frame counter stays within one framed byte
    assert_len_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        remain_q <= LEN_W'(FRAME_W));

    // R5: entering the shifter empties the holding register and raises the request
    assert_load_request_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(active_q) && !$past(cfg_we_i)) |-> (!hold_full_q && pend_q));

    // R8: one valid pulse per strobe
    assert_vld_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
        tick_i |=> sample_vld_o);
    assert_vld_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_i |=> !sample_vld_o);

    // R8: phase moves only on strobes
    assert_phase_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_i |=> $stable(phase_q));

    // R11: disabled strobes give silence and no phase step
    assert_disabled_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !tx_en_q) |=> (sample_o == '0 && $stable(phase_q)));

    // R7: idle line rests on mark
    assert_idle_mark_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!active_q && !$past(active_q)) |-> line_bit_o);
endmodule

bind cid_fsk_mod cid_fsk_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .tick_i       (tick_i),
    .cfg_we_i     (cfg_we_i),
    .cfg_addr_i   (cfg_addr_i),
    .cfg_wdata_i  (cfg_wdata_i),
    .irq_o        (irq_o),
    .line_bit_o   (line_bit_o),
    .sample_vld_o (sample_vld_o),
    .sample_o     (sample_o),
    .pend_q       (q.pend),
    .irq_en_q     (q.irq_en),
    .tx_en_q      (q.tx_en),
    .active_q     (q.active),
    .hold_full_q  (q.hold_full),
    .remain_q     (q.remain),
    .phase_q      (q.phase)
);

// File: tb/cid_fsk_mod_tb_top.sv
`timescale 1ns/1ps
module cid_fsk_mod_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_i = 1'b0;
    logic        cfg_we_i = 1'b0;
    logic [2:0]  cfg_addr_i = '0;
    logic [15:0] cfg_wdata_i = '0;
    logic        irq_o, line_bit_o, sample_vld_o;
    logic signed [15:0] sample_o;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    // bench-side model state
    int unsigned m_phase = 0;
    int m_fm = 0, m_fs = 0, m_am = 0, m_as = 0;
    bit m_en = 0;
    bit ev [0:79];
    int ev_n = 0;
    bit saw_max = 0, saw_min = 0;

    always #2.5 clk = ~clk;

    cid_fsk_mod dut_i (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i),
        .cfg_we_i(cfg_we_i), .cfg_addr_i(cfg_addr_i), .cfg_wdata_i(cfg_wdata_i),
        .irq_o(irq_o), .line_bit_o(line_bit_o),
        .sample_vld_o(sample_vld_o), .sample_o(sample_o)
    );

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    task automatic wr(input int a, input int v);
        @(negedge clk);
        cfg_we_i = 1'b1; cfg_addr_i = 3'(a); cfg_wdata_i = 16'(v);
        @(negedge clk);
        cfg_we_i = 1'b0;
        case (a)
            1: m_en = v[2];
            3: m_fm = v & 16'hFFF8;
            4: m_fs = v & 16'hFFF8;
            5: m_am = v & 16'hFFF8;
            6: m_as = v & 16'hFFF8;
            default: ;
        endcase
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic int model_sample(input int unsigned ph, input int amp);
        int q, i, mag, s;
        longint p;
        q = (ph >> 14) & 3;
        i = (ph >> 10) & 15;
        if (q & 1) i = 15 - i;
        mag = $rtoi(32767.0 * $sin((2.0 * i + 1.0) * 3.14159265358979 / 64.0) + 0.5);
        s = (q & 2) ? -mag : mag;
        p = (longint'(s) * amp) >>> 15;
        if (p > 32767) p = 32767;
        if (p < -32768) p = -32768;
        return int'(p);
    endfunction

    // one strobe; returns the bit in use, checks the sample (R8, R9, R11)
    task automatic strobe(output bit b);
        int e, a;
        @(negedge clk);
        tick_i = 1'b1;
        b = line_bit_o;
        @(negedge clk);
        tick_i = 1'b0;
        a = int'(sample_o);
        chk(sample_vld_o == 1'b1, "R8 valid pulse", int'(sample_vld_o), 1);
        if (m_en) begin
            e = model_sample(m_phase, b ? m_am : m_as);
            chk((a - e <= 6) && (e - a <= 6), "R8/R9 sample value", a, e);
            if (a == 32767) saw_max = 1;
            if (a == -32768) saw_min = 1;
            m_phase = (m_phase + (b ? m_fm : m_fs)) & 16'hFFFF;
        end else begin
            chk(a == 0, "R11 disabled sample", a, 0);
        end
    endtask

    task automatic add_frame(input int dat, input bit bare, input int per);
        int pe;
        pe = (per == 0) ? 1 : per;
        if (!bare) for (int r = 0; r < pe; r++) begin ev[ev_n] = 1'b0; ev_n++; end
        for (int k = 0; k < 8; k++)
            for (int r = 0; r < pe; r++) begin ev[ev_n] = dat[k]; ev_n++; end
        if (!bare) for (int r = 0; r < pe; r++) begin ev[ev_n] = 1'b1; ev_n++; end
    endtask

    task automatic run_ev(input string rq);
        bit b;
        for (int i = 0; i < ev_n; i++) begin
            strobe(b);
            chk(b == ev[i], rq, int'(b), int'(ev[i]));
        end
        ev_n = 0;
    endtask

    task automatic t_reset;
        idle(1);
        chk(irq_o == 0, "R1 irq at reset", int'(irq_o), 0);
        chk(sample_vld_o == 0, "R1 valid at reset", int'(sample_vld_o), 0);
        chk(sample_o == 0, "R1 sample at reset", int'(sample_o), 0);
        chk(line_bit_o == 1, "R1 line at reset", int'(line_bit_o), 1);
    endtask

    task automatic t_disabled;
        bit b;
        wr(1, 3'b010);
        wr(0, 8'h3C);
        idle(2);
        strobe(b);
        chk(b == 1, "R11 no load when disabled", int'(b), 1);
        chk(irq_o == 0, "R11 no request when disabled", int'(irq_o), 0);
    endtask

    task automatic t_framed;
        bit b;
        wr(3, 16'h0CCF);  // mark word, low bits set (R9)
        wr(4, 16'h1775);
        wr(5, 16'h8007);
        wr(6, 16'h4005);
        wr(2, 3);
        strobe(b);
        chk(b == 1, "R7 idle mark", int'(b), 1);
        wr(1, 3'b110);   // enabling loads the held 0x3C byte
        idle(2);
        chk(irq_o == 1, "R5 request on load", int'(irq_o), 1);
        add_frame(8'h3C, 0, 3);
        run_ev("R2 framed bit order");
        strobe(b);
        chk(b == 1, "R7 mark after frame", int'(b), 1);
        wr(7, 1);
        chk(irq_o == 0, "R6 cleared", int'(irq_o), 0);
        wr(0, 8'hA5);
        idle(2);
        add_frame(8'hA5, 0, 3);
        run_ev("R2 framed bit order A5");
        wr(7, 1);
    endtask

    task automatic t_bare;
        wr(1, 3'b111);
        wr(2, 2);
        wr(0, 8'h96);
        idle(2);
        add_frame(8'h96, 1, 2);
        run_ev("R3 bare byte");
        wr(7, 1);
    endtask

    task automatic t_period0;
        wr(1, 3'b110);
        wr(2, 0);
        wr(0, 8'h5B);
        idle(2);
        add_frame(8'h5B, 0, 0);
        run_ev("R4 zero period");
        wr(2, 1);
        wr(0, 8'hC1);
        idle(2);
        add_frame(8'hC1, 0, 1);
        run_ev("R4 one-sample period");
        wr(7, 1);
    endtask

    task automatic t_double;
        bit b;
        wr(2, 2);
        wr(0, 8'h81);
        idle(2);
        wr(7, 1);
        chk(irq_o == 0, "R6 clear after load", int'(irq_o), 0);
        add_frame(8'h81, 0, 2);
        for (int i = 0; i < 6; i++) begin
            strobe(b);
            chk(b == ev[i], "R5 first byte head", int'(b), int'(ev[i]));
        end
        wr(0, 8'h7E);
        idle(2);
        chk(irq_o == 0, "R5 held while busy", int'(irq_o), 0);
        for (int i = 6; i < 20; i++) begin
            strobe(b);
            chk(b == ev[i], "R5 first byte tail", int'(b), int'(ev[i]));
        end
        chk(irq_o == 1, "R5 request at back-to-back load", int'(irq_o), 1);
        ev_n = 0;
        add_frame(8'h7E, 0, 2);
        run_ev("R5 second byte no gap");
        wr(1, 3'b100);
        chk(irq_o == 0, "R6 gated off", int'(irq_o), 0);
        wr(1, 3'b110);
        chk(irq_o == 1, "R6 still pending", int'(irq_o), 1);
        wr(7, 1);
        chk(irq_o == 0, "R6 w1c", int'(irq_o), 0);
    endtask

    task automatic t_sat;
        bit b;
        wr(3, 16'h0400);
        wr(5, 16'hFFF8);
        for (int i = 0; i < 64; i++) begin
            strobe(b);
            chk(b == 1, "R7 idle during sweep", int'(b), 1);
        end
        chk(saw_max, "R10 clamp high", int'(saw_max), 1);
        chk(saw_min, "R10 clamp low", int'(saw_min), 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        t_reset;
        idle(2);
        rst_n = 1'b1;
        t_reset;
        t_disabled;
        t_framed;
        t_bare;
        t_period0;
        t_double;
        t_sat;
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule